// File: doc/BRIEF.md
# Bit-Field Extract and Lowest-Set-Bit Unit

This execution unit computes one result per accepted operation for five scalar bit-manipulation operations on a 32-bit or 64-bit operand. There are two field operations. The first extracts a field at a start position with a length. The second clears every bit from an index upward. The other three work on the lowest set bit: isolate it, build a mask through it, or clear it. Every start, length and index value is defined, including values past the operand width, so the unit never yields a width-dependent or undefined result.

An upstream decoder presents the operand, a 16-bit control word, an operation code and a size select, and qualifies them with `in_valid`. One clock later the unit returns the result with carry, zero, sign and overflow flags. In narrow mode the unit drops the operand's upper half before it computes, and the upper half of the result is always zero. Carry for the lowest-set-bit operations comes from the source operand, not from the result.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `out_valid`=0, `out_res`=0, and carry, zero and sign all 0.
- R2: The outputs of an operation accepted with `in_valid`=1 appear after exactly one clock edge, with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0 on the next cycle and leaves result and flags unchanged.
- R3: Field extract (op code 0): the start is `in_ctl[7:0]` and the length is `in_ctl[15:8]`. The operand is shifted right by the start, and the low length bits are kept. A start above width-1 gives 0. A length of 0 gives 0. A length above width-1 keeps every shifted bit. Carry is 0.
- R4: With `in_wide`=0 (32-bit), operand bits 63:32 are ignored, and result bits 63:32 are 0 for every operation.
- R5: Zero-high (op code 1): the index is `in_ctl[7:0]`, and bits at the index and above are cleared. If the index is width or more, the operand is returned unchanged and carry is 1; otherwise carry is 0.
- R6: Isolate (op 2) returns src & -src. Mask-through (op 3) returns src ^ (src-1). Clear-lowest (op 4) returns src & (src-1). All three are evaluated at the selected width, e.g. 0x30 gives 0x10, 0x1f and 0x20.
- R7: Carry for op 2 is 1 exactly when the source at the selected width is nonzero. Carry for ops 3 and 4 is 1 exactly when that source is zero.
- R8: Overflow is always 0. Zero is 1 exactly when the result is 0. Sign is bit 63 of the result in 64-bit mode and bit 31 in 32-bit mode.
- R9: Op codes 5 to 7 return a zero result with carry 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0 extract, 1 zero-high, 2 isolate, 3 mask-through, 4 clear-lowest) |
| in_wide | input | 1 | 1 selects 64-bit width, 0 selects 32-bit |
| in_src | input | 64 | Source operand |
| in_ctl | input | 16 | Control: start/index in 7:0, length in 15:8 |
| out_valid | output | 1 | Result valid |
| out_res | output | 64 | Result |
| out_carry | output | 1 | Carry flag |
| out_zero | output | 1 | Zero flag |
| out_sign | output | 1 | Sign flag |
| out_ovf | output | 1 | Overflow flag (always 0) |

## Verification
The unit holds no state besides its output register, so a wrong value in that register shows at the ports on the cycle right after the operation. A bad width limit in the range checks shows up only at the edges: start, length or index equal to width-1, width, or 0x7f/0xff. The vectors sit on both sides of each limit in both modes. Narrow-mode leakage shows as nonzero upper result bits, or as a wrong carry when the upper source half is nonzero and the lower half is zero.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    OP_FIELD  = 3'd0,
    OP_ZHI    = 3'd1,
    OP_ISOL   = 3'd2,
    OP_UPMASK = 3'd3,
    OP_DROP   = 3'd4
  } bf_op_e;

  localparam int IDXW = 8;
endpackage

// File: rtl/bf_field.sv
// Field extract and zero-high datapath; src arrives already narrowed.
module bf_field #(
  parameter int XLEN = 64,
  parameter int NLEN = 32,
  parameter int IDXW = 8
) (
  input  logic [XLEN-1:0]   src,
  input  logic              wide,
  input  logic [2*IDXW-1:0] ctl,
  output logic [XLEN-1:0]   ext_res,
  output logic [XLEN-1:0]   zhi_res,
  output logic              zhi_carry
);
  localparam logic [IDXW-1:0] LIM_W = IDXW'(XLEN - 1);
  localparam logic [IDXW-1:0] LIM_N = IDXW'(NLEN - 1);
  localparam logic [XLEN-1:0] ONES  = {XLEN{1'b1}};

  logic [IDXW-1:0] lim, start, len;
  logic [XLEN-1:0] shifted, keep;

  always_comb begin
    lim   = wide ? LIM_W : LIM_N;
    start = ctl[IDXW-1:0];
    len   = ctl[2*IDXW-1:IDXW];
    // start past the top bit saturates to an empty field
    shifted = (start <= lim) ? (src >> start) : '0;
    // length past the top bit saturates to keeping everything
    keep    = (len <= lim) ? ~(ONES << len) : ONES;
    ext_res = shifted & keep;
    // zero-high reuses the start field as its index
    zhi_carry = (start > lim);
    zhi_res   = zhi_carry ? src : (src & ~(ONES << start));
  end
endmodule

// File: rtl/bf_lowbit.sv
// Lowest-set-bit operations on an already narrowed source.
module bf_lowbit #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] isol,
  output logic [XLEN-1:0] upmask,
  output logic [XLEN-1:0] drop,
  output logic            src_nz
);
  logic [XLEN-1:0] dec, neg;

  always_comb begin
    dec    = src - XLEN'(1);
    neg    = ~src + XLEN'(1);
    isol   = src & neg;
    upmask = src ^ dec;
    drop   = src & dec;
    src_nz = |src;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int XLEN = 64,
  parameter int NLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      in_op,
  input  logic            in_wide,
  input  logic [XLEN-1:0] in_src,
  input  logic [15:0]     in_ctl,
  output logic            out_valid,
  output logic [XLEN-1:0] out_res,
  output logic            out_carry,
  output logic            out_zero,
  output logic            out_sign,
  output logic            out_ovf
);
  import bf_pkg::*;

  localparam int HIW = XLEN - NLEN;
  localparam logic [XLEN-1:0] NMASK = {{HIW{1'b0}}, {NLEN{1'b1}}};

  logic [XLEN-1:0] wmask, src_n;
  logic [XLEN-1:0] ext_res, zhi_res, isol, upmask, drop;
  logic            zhi_carry, src_nz;
  logic [XLEN-1:0] res_c;
  logic            carry_c, zero_c, sign_c;

  always_comb begin
    wmask = in_wide ? {XLEN{1'b1}} : NMASK;
    src_n = in_src & wmask;
  end

  bf_field #(.XLEN(XLEN), .NLEN(NLEN), .IDXW(IDXW)) u_field (
    .src       (src_n),
    .wide      (in_wide),
    .ctl       (in_ctl),
    .ext_res   (ext_res),
    .zhi_res   (zhi_res),
    .zhi_carry (zhi_carry)
  );

  bf_lowbit #(.XLEN(XLEN)) u_lowbit (
    .src    (src_n),
    .isol   (isol),
    .upmask (upmask),
    .drop   (drop),
    .src_nz (src_nz)
  );

  always_comb begin
    res_c   = '0;
    carry_c = 1'b0;
    case (in_op)
      OP_FIELD:  res_c = ext_res;
      OP_ZHI:    begin res_c = zhi_res; carry_c = zhi_carry; end
      OP_ISOL:   begin res_c = isol;    carry_c = src_nz;    end
      OP_UPMASK: begin res_c = upmask;  carry_c = ~src_nz;   end
      OP_DROP:   begin res_c = drop;    carry_c = ~src_nz;   end
      default:   ;
    endcase
    res_c  = res_c & wmask;
    zero_c = (res_c == '0);
    sign_c = in_wide ? res_c[XLEN-1] : res_c[NLEN-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_carry <= 1'b0;
      out_zero  <= 1'b0;
      out_sign  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res   <= res_c;
        out_carry <= carry_c;
        out_zero  <= zero_c;
        out_sign  <= sign_c;
      end
    end
  end

  assign out_ovf = 1'b0;
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk #(
  parameter int XLEN = 64,
  parameter int NLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      in_op,
  input logic            in_wide,
  input logic            out_valid,
  input logic [XLEN-1:0] out_res,
  input logic            out_carry,
  input logic            out_zero
);
  import bf_pkg::*;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_res) && $stable(out_carry) && $stable(out_zero)));

  a_r4_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide) |=> (out_res[XLEN-1:NLEN] == '0));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zero == (out_res == '0)));

  a_r6_isol_onehot: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ISOL) |=> $onehot0(out_res));

  a_r7_isol_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ISOL) |=> (out_carry == (out_res != '0)));
endmodule

bind bitfield_unit bf_unit_chk #(.XLEN(XLEN), .NLEN(NLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_wide   (in_wide),
  .out_valid (out_valid),
  .out_res   (out_res),
  .out_carry (out_carry),
  .out_zero  (out_zero)
);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic        in_wide = 1'b1;
  logic [63:0] in_src = '0;
  logic [15:0] in_ctl = '0;
  logic        out_valid, out_carry, out_zero, out_sign, out_ovf;
  logic [63:0] out_res;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitfield_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .in_src(in_src), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_res(out_res), .out_carry(out_carry),
    .out_zero(out_zero), .out_sign(out_sign), .out_ovf(out_ovf)
  );

  localparam int NV = 24;
  // op codes: 0 extract, 1 zero-high, 2 isolate, 3 mask-through, 4 clear-lowest
  localparam logic [2:0] T_OP [NV] = '{
    3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
    3'd1, 3'd1, 3'd1, 3'd1, 3'd1,
    3'd2, 3'd3, 3'd4, 3'd3, 3'd2,
    3'd2, 3'd3, 3'd4, 3'd2,
    3'd5, 3'd4, 3'd2};
  localparam logic T_WIDE [NV] = '{
    1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
    1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b1};
  localparam logic [63:0] T_SRC [NV] = '{
    64'ha080800302020001, 64'ha080800302020001, 64'hfedcba9876543210,
    64'h8f635a775ad3b9b4, 64'hfedcba9876543210, 64'hffffffffffffffff,
    64'h202020204f4c4845,
    64'ha080800302020001, 64'ha080800302020001, 64'ha080800302020001,
    64'hffffffffffffffff, 64'hffffffffffffffff,
    64'h30, 64'h30, 64'h30, 64'h300, 64'h0000003000000000,
    64'h0, 64'h0, 64'h0, 64'h0000000100000000,
    64'h1234, 64'h8000000000000000, 64'h8000000000000000};
  localparam logic [15:0] T_CTL [NV] = '{
    16'h1038, 16'h10f8, 16'h7f00, 16'h3018, 16'h7f00, 16'h0000, 16'h1018,
    16'h0040, 16'h003f, 16'h000f, 16'h0020, 16'h001f,
    16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
    16'h0, 16'h0, 16'h0, 16'h0,
    16'hffff, 16'h0, 16'h0};
  localparam logic [63:0] T_EXP [NV] = '{
    64'ha0, 64'h0, 64'hfedcba9876543210, 64'h5a, 64'h76543210, 64'h0, 64'h4f,
    64'ha080800302020001, 64'h2080800302020001, 64'h1, 64'hffffffff, 64'h7fffffff,
    64'h10, 64'h1f, 64'h20, 64'h1ff, 64'h0000001000000000,
    64'h0, 64'hffffffff, 64'h0, 64'h0,
    64'h0, 64'h0, 64'h8000000000000000};
  localparam logic T_C [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
    1'b0, 1'b1, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b1};
  // requirement per vector: R3 extract, R4 narrow mode, R5 zero-high,
  // R6 lowest-bit values, R7 lowest-bit carry, R9 unused codes
  localparam int T_REQ [NV] = '{
    3, 3, 3, 4, 4, 3, 3,
    5, 5, 5, 4, 5,
    6, 6, 6, 6, 6,
    7, 7, 7, 4,
    9, 7, 7};

  task automatic check(input int req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    finish_run();
  end

  initial begin
    logic [63:0] last_res;
    logic        last_c;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "reset valid", 64'(out_valid), 64'd0);
    check(1, "reset res", out_res, 64'd0);
    check(1, "reset flags", {61'd0, out_carry, out_zero, out_sign}, 64'd0);
    rst = 1'b0;

    // vector table, one operation per cycle, checked one edge later (R2)
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_op    = T_OP[i];
      in_wide  = T_WIDE[i];
      in_src   = T_SRC[i];
      in_ctl   = T_CTL[i];
      @(negedge clk);
      check(2, $sformatf("v%0d valid", i), 64'(out_valid), 64'd1);
      check(T_REQ[i], $sformatf("v%0d result", i), out_res, T_EXP[i]);
      check(T_REQ[i], $sformatf("v%0d carry", i), 64'(out_carry), 64'(T_C[i]));
      // R8 flags from the expected result at the selected width
      check(8, $sformatf("v%0d zero", i), 64'(out_zero), 64'(T_EXP[i] == 64'd0));
      check(8, $sformatf("v%0d sign", i), 64'(out_sign),
            64'(T_WIDE[i] ? T_EXP[i][63] : T_EXP[i][31]));
      check(8, $sformatf("v%0d overflow", i), 64'(out_ovf), 64'd0);
    end

    // R2 idle cycle holds result and flags even with new inputs present
    last_res = out_res;
    last_c   = out_carry;
    in_valid = 1'b0;
    in_op    = 3'd2;
    in_wide  = 1'b1;
    in_src   = 64'h40;
    @(negedge clk);
    check(2, "idle valid", 64'(out_valid), 64'd0);
    check(2, "idle hold res", out_res, last_res);
    check(2, "idle hold carry", 64'(out_carry), 64'(last_c));

    // R2 accepted again after the gap
    in_valid = 1'b1;
    @(negedge clk);
    check(2, "resume valid", 64'(out_valid), 64'd1);
    check(6, "resume isolate 0x40", out_res, 64'h40);

    // R3 length exactly width-1 in 64-bit mode keeps 63 bits
    in_op = 3'd0; in_src = 64'hffffffffffffffff; in_ctl = 16'h3f00;
    @(negedge clk);
    check(3, "extract len 63", out_res, 64'h7fffffffffffffff);

    // R3 start exactly width-1 in 32-bit mode
    in_wide = 1'b0; in_src = 64'h0000000080000000; in_ctl = 16'h081f;
    @(negedge clk);
    check(3, "extract start 31", out_res, 64'h1);

    // R3 start 32 in 32-bit mode is past the width
    in_ctl = 16'h0820;
    @(negedge clk);
    check(3, "extract start 32 narrow", out_res, 64'h0);

    // R5 index 0xff in 64-bit mode
    in_op = 3'd1; in_wide = 1'b1; in_src = 64'h8000000000000001; in_ctl = 16'h00ff;
    @(negedge clk);
    check(5, "zhi idx 0xff res", out_res, 64'h8000000000000001);
    check(5, "zhi idx 0xff carry", 64'(out_carry), 64'd1);

    // R5 index 0 clears everything
    in_ctl = 16'h0000;
    @(negedge clk);
    check(5, "zhi idx 0 res", out_res, 64'h0);
    check(5, "zhi idx 0 carry", 64'(out_carry), 64'd0);

    // R1 reset while an operation is presented
    rst = 1'b1;
    @(negedge clk);
    check(1, "mid reset valid", 64'(out_valid), 64'd0);
    check(1, "mid reset res", out_res, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule